// File: doc/BRIEF.md
# Clock-Stretching I2C Target

This block is an I2C target (slave) with one fixed 7-bit address. It watches the open-drain SCL and SDA lines through a synchronizer and detects START and STOP. It shifts in the address byte and acknowledges it when the address matches. It then either accepts bytes from the controller or sends bytes to it. On the user side, received bytes leave through a valid/ready output, and bytes to transmit arrive through a valid/ready input.

The block never drives a line high. Its two bus outputs are pull-low enables that feed open-drain pads. When the user side is slow, the block holds SCL low after the acknowledge bit of a byte, which makes the controller wait. In a write, it waits until the received byte has been taken. In a read, it waits until the next byte has been supplied. Reads and writes therefore run at the pace of the back end, and no byte is lost.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset, neither SCL nor SDA is pulled low, rxValid is low and txReady is low.
- R2: START (SDA falling while SCL is high) begins address reception from any state. STOP (SDA rising while SCL is high) returns the block to idle, where clocked bits are not acknowledged. The block changes its SDA pull only while SCL is low.
- R3: The first seven bits after START are taken MSB first and compared with OWN_ADDR. OWN_ADDR holds a 4-bit device-type field in bits 6..3 and a 3-bit select field in bits 2..0. The eighth bit selects the direction: 0 is write and 1 is read. On a match, SDA is pulled low for the ninth clock (ACK).
- R4: In a write, each data byte is taken MSB first and acknowledged. It is then presented on rxData with rxValid high, and rxData stays unchanged until rxReady is seen high.
- R5: In a write, if the byte has not been taken when the ACK clock falls, SCL is held low until it is taken. A new byte is never captured while one is still pending.
- R6: On an address mismatch, SDA stays released during the ninth clock, no byte is presented, and neither line is pulled until the next START or STOP.
- R7: In a read, after the address ACK and after each ACK from the controller, SCL is held low with txReady high until txValid. The accepted byte is then sent MSB first.
- R8: In a read, SDA high at the ninth rising SCL edge (NACK) ends the transmission. SDA is released and txReady stays low until the next START.
- R9: A repeated START in the middle of a byte or after a byte restarts address reception. A new direction takes effect from the new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Level of the SCL line |
| sdaIn | input | 1 | Level of the SDA line |
| sclPullLow | output | 1 | 1 pulls SCL low (stretch); 0 releases it |
| sdaPullLow | output | 1 | 1 pulls SDA low; 0 releases it |
| rxData | output | 8 | Byte received in a write |
| rxValid | output | 1 | rxData holds a byte not yet taken |
| rxReady | input | 1 | User side takes rxData |
| txData | input | 8 | Next byte to send in a read |
| txValid | input | 1 | txData is available |
| txReady | output | 1 | Block is waiting for a byte to send |

## Verification
The assertions assume that SCL stays low, and SCL and SDA stay stable, for many more system clocks than the synchronizer depth. This lets every bus edge be seen as one clean transition. They also assume the controller honours the stretch and moves SDA only while SCL is low, except to form START and STOP. The bench controller is a bit-level model that keeps each SCL quarter period at ten system clocks. It waits for SCL to actually go high before it counts the high time, and it drives SDA a quarter period after each falling edge. This keeps every transfer inside those assumptions.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BITS,
    ST_WR_ACK,
    ST_WR_HOLD,
    ST_RD_WAIT,
    ST_RD_BITS,
    ST_RD_ACK,
    ST_RD_ACKED,
    ST_IGNORE
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic capRx;
  } dpStrobe_t;

endpackage

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [BYTE_W-2:0] OWN_ADDR   = 7'h53
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] txData,
  input  logic              rxReady,
  output logic              sclS,
  output logic              sdaS,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              cntFull,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              txBit,
  output logic              rxPend,
  output logic [BYTE_W-1:0] rxData
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic                   sclP, sdaP;
  logic [BYTE_W-1:0]      shReg, rxHold;
  logic [CNT_W-1:0]       bitCnt;

  // line synchronizers, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shReg  <= '0;
      rxHold <= '0;
      rxPend <= 1'b0;
    end else begin
      if (strobe.clrCnt)                         bitCnt <= '0;
      else if (strobe.shiftIn | strobe.shiftOut) bitCnt <= bitCnt + 1'b1;

      if (strobe.loadTx)        shReg <= txData;
      else if (strobe.shiftIn)  shReg <= {shReg[BYTE_W-2:0], sdaS};
      else if (strobe.shiftOut) shReg <= {shReg[BYTE_W-2:0], 1'b0};

      if (strobe.capRx) begin
        rxHold <= shReg;
        rxPend <= 1'b1;
      end else if (rxPend && rxReady) begin
        rxPend <= 1'b0;
      end
    end
  end

  assign cntFull   = (bitCnt == CNT_W'(BYTE_W));
  assign addrMatch = (shReg[BYTE_W-1:1] == OWN_ADDR);
  assign rwBit     = shReg[0];
  assign txBit     = shReg[BYTE_W-1];
  assign rxData    = rxHold;

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxPend && !rxReady) |=> (rxPend && $stable(rxData)));

  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capRx |-> !rxPend);

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclS,
  input  logic      sdaS,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      cntFull,
  input  logic      addrMatch,
  input  logic      rwBit,
  input  logic      txBit,
  input  logic      rxPend,
  input  logic      rxReady,
  input  logic      txValid,
  output dpStrobe_t strobe,
  output logic      sclPullLow,
  output logic      sdaPullLow,
  output logic      txReady
);

  ctrlState_e st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt    = st;
    strobe = '0;
    if (startDet) begin
      nxt           = ST_ADDR;
      strobe.clrCnt = 1'b1;
    end else if (stopDet) begin
      nxt = ST_IDLE;
    end else begin
      unique case (st)
        ST_ADDR: begin
          if (sclRise && !cntFull) strobe.shiftIn = 1'b1;
          else if (sclFall && cntFull) nxt = addrMatch ? ST_ADDR_ACK : ST_IGNORE;
        end
        ST_ADDR_ACK: if (sclFall) begin
          strobe.clrCnt = 1'b1;
          nxt           = rwBit ? ST_RD_WAIT : ST_WR_BITS;
        end
        ST_WR_BITS: begin
          if (sclRise && !cntFull) strobe.shiftIn = 1'b1;
          else if (sclFall && cntFull) begin
            strobe.capRx = 1'b1;
            nxt          = ST_WR_ACK;
          end
        end
        ST_WR_ACK: if (sclFall) begin
          strobe.clrCnt = 1'b1;
          nxt           = (rxPend && !rxReady) ? ST_WR_HOLD : ST_WR_BITS;
        end
        ST_WR_HOLD: if (!rxPend) nxt = ST_WR_BITS;
        ST_RD_WAIT: if (txValid) begin
          strobe.loadTx = 1'b1;
          strobe.clrCnt = 1'b1;
          nxt           = ST_RD_BITS;
        end
        ST_RD_BITS: begin
          if (cntFull) nxt = ST_RD_ACK;
          else if (sclFall) strobe.shiftOut = 1'b1;
        end
        ST_RD_ACK:   if (sclRise) nxt = sdaS ? ST_IGNORE : ST_RD_ACKED;
        ST_RD_ACKED: if (sclFall) nxt = ST_RD_WAIT;
        default: ;
      endcase
    end
  end

  assign sdaPullLow = (st == ST_ADDR_ACK) || (st == ST_WR_ACK) ||
                      ((st == ST_RD_BITS) && !txBit && !cntFull);
  assign sclPullLow = (st == ST_WR_HOLD) || (st == ST_RD_WAIT);
  assign txReady    = (st == ST_RD_WAIT);

  assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !$past(sclS));

  assert_stretch_starts_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclPullLow) |-> !$past(sclS));

  assert_mismatch_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ADDR && sclFall && cntFull && !addrMatch && !startDet && !stopDet)
      |=> (!sdaPullLow && !sclPullLow));

  assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RD_ACK && sclRise && sdaS && !startDet && !stopDet)
      |=> (!sdaPullLow && !txReady));

endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
  import i2cs_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [BYTE_W-2:0] OWN_ADDR   = 7'h53
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady
);

  dpStrobe_t strobe;
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic cntFull, addrMatch, rwBit, txBit, rxPend;

  i2cs_datapath #(.SYNC_STAGES(SYNC_STAGES), .OWN_ADDR(OWN_ADDR)) u_dp (
    .clk, .rstN, .sclIn, .sdaIn, .strobe, .txData, .rxReady,
    .sclS, .sdaS, .sclRise, .sclFall, .startDet, .stopDet,
    .cntFull, .addrMatch, .rwBit, .txBit, .rxPend, .rxData
  );

  i2cs_ctrl u_ctrl (
    .clk, .rstN, .sclS, .sdaS, .sclRise, .sclFall, .startDet, .stopDet,
    .cntFull, .addrMatch, .rwBit, .txBit, .rxPend, .rxReady, .txValid,
    .strobe, .sclPullLow, .sdaPullLow, .txReady
  );

  assign rxValid = rxPend;

endmodule

// File: tb/i2c_stretch_slave_tb.sv
module i2c_stretch_slave_tb;

  localparam logic [6:0] OWN = 7'h53;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterScl = 1'b1, masterSda = 1'b1;
  logic sclPullLow, sdaPullLow, rxValid, txReady;
  logic rxReady = 1'b0, txValid = 1'b0;
  logic [7:0] rxData, txData = 8'h00;
  logic sclLine, sdaLine;

  int checks = 0, errors = 0;
  int stretchCnt = 0, rxGot = 0;
  int rxDelay = 0, rxWait = 0, txDelay = 0, txWait = 0;
  bit readActive = 0, done = 0;
  byte unsigned expRx[$];
  byte unsigned txQ[$];

  always #10 clk = ~clk;

  assign sclLine = masterScl & ~sclPullLow;
  assign sdaLine = masterSda & ~sdaPullLow;

  i2c_stretch_slave #(.OWN_ADDR(OWN)) u_dut (
    .clk, .rstN, .sclIn(sclLine), .sdaIn(sdaLine), .sclPullLow, .sdaPullLow,
    .rxData, .rxValid, .rxReady, .txData, .txValid, .txReady
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // back-end models and per-clock comparison against the expected traffic
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rxValid && expRx.size() == 0) chk(0, "R6 rxValid with no byte expected", 1, 0);
      if (txReady && !readActive)       chk(0, "R8 txReady outside a read", 1, 0);
      if (rxReady) rxReady = 0;
      else if (rxValid) begin
        if (rxWait < rxDelay) rxWait++;
        else begin
          rxWait = 0;
          rxReady = 1;
          if (expRx.size() > 0) begin
            automatic byte unsigned e = expRx.pop_front();
            chk(rxData == e, "R4 received byte", rxData, e);
            rxGot++;
          end
        end
      end
      if (txValid) txValid = 0;
      else if (txReady) begin
        if (txWait < txDelay) txWait++;
        else begin
          txWait = 0;
          txData = (txQ.size() > 0) ? txQ.pop_front() : 8'h00;
          txValid = 1;
        end
      end
    end
  end

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic releaseScl();
    masterScl = 1;
    @(negedge clk);
    while (!sclLine) begin
      stretchCnt++;
      @(negedge clk);
    end
  endtask

  task automatic startCond();
    masterSda = 1; waitC(Q);
    releaseScl(); waitC(Q);
    masterSda = 0; waitC(2*Q);
    masterScl = 0; waitC(Q);
  endtask

  task automatic stopCond();
    masterSda = 0; waitC(Q);
    releaseScl(); waitC(2*Q);
    masterSda = 1; waitC(2*Q);
  endtask

  task automatic writeBit(input bit b);
    masterSda = b; waitC(Q);
    releaseScl(); waitC(2*Q);
    masterScl = 0; waitC(Q);
  endtask

  task automatic readBit(output bit b);
    masterSda = 1; waitC(Q);
    releaseScl(); waitC(Q);
    b = sdaLine; waitC(Q);
    masterScl = 0; waitC(Q);
  endtask

  task automatic writeByte(input byte unsigned v, output bit ack);
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(ack);
  endtask

  task automatic readByte(input bit ackBit, output byte unsigned v);
    for (int i = 7; i >= 0; i--) begin
      automatic bit b;
      readBit(b);
      v[i] = b;
    end
    writeBit(ackBit);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog expired", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    byte unsigned v;
    waitC(5);
    chk(sclPullLow == 0 && sdaPullLow == 0, "R1 lines released in reset", {sclPullLow, sdaPullLow}, 0);
    waitC(5);
    rstN = 1;
    waitC(3);
    chk(sclPullLow == 0 && sdaPullLow == 0, "R1 lines released after reset", {sclPullLow, sdaPullLow}, 0);
    chk(rxValid == 0 && txReady == 0, "R1 handshakes idle after reset", {rxValid, txReady}, 0);

    // write of two bytes, slow consumer
    rxDelay = 60;
    expRx.push_back(8'hA5);
    expRx.push_back(8'h3C);
    startCond();
    writeByte({OWN, 1'b0}, ack);
    chk(ack == 0, "R3 address ACK for write", ack, 0);
    stretchCnt = 0;
    writeByte(8'hA5, ack);
    chk(ack == 0, "R4 data byte ACK", ack, 0);
    writeByte(8'h3C, ack);
    chk(ack == 0, "R4 second data byte ACK", ack, 0);
    chk(stretchCnt > 0, "R5 SCL stretched for slow consumer", stretchCnt, 1);
    stopCond();
    waitC(4*Q);
    chk(rxGot == 2, "R4 bytes delivered", rxGot, 2);

    // after STOP, clocked bits without START get no ACK
    masterScl = 0; waitC(Q);
    writeByte({OWN, 1'b0}, ack);
    chk(ack == 1, "R2 no ACK without START after STOP", ack, 1);
    stopCond();

    // address mismatch
    rxDelay = 0;
    startCond();
    writeByte({7'h52, 1'b0}, ack);
    chk(ack == 1, "R6 no ACK for other address", ack, 1);
    writeByte(8'h00, ack);
    chk(ack == 1, "R6 data ignored after mismatch", ack, 1);
    chk(sclPullLow == 0 && sdaPullLow == 0, "R6 lines released after mismatch", {sclPullLow, sdaPullLow}, 0);
    stopCond();

    // read of two bytes, slow producer, NACK on the last
    readActive = 1;
    txDelay = 40;
    txQ.push_back(8'h96);
    txQ.push_back(8'h01);
    startCond();
    writeByte({OWN, 1'b1}, ack);
    chk(ack == 0, "R3 address ACK for read", ack, 0);
    stretchCnt = 0;
    readByte(1'b0, v);
    chk(v == 8'h96, "R7 first read byte", v, 8'h96);
    chk(stretchCnt > 0, "R7 SCL stretched for slow producer", stretchCnt, 1);
    readByte(1'b1, v);
    chk(v == 8'h01, "R7 second read byte", v, 8'h01);
    readActive = 0;
    waitC(4*Q);
    chk(sdaPullLow == 0 && txReady == 0, "R8 released after NACK", {sdaPullLow, txReady}, 0);
    stopCond();

    // repeated START mid-byte, then write, then repeated START into a read
    startCond();
    writeByte({OWN, 1'b0}, ack);
    writeBit(1'b1);
    writeBit(1'b0);
    startCond();
    expRx.push_back(8'h7E);
    writeByte({OWN, 1'b0}, ack);
    chk(ack == 0, "R9 address ACK after repeated START mid-byte", ack, 0);
    writeByte(8'h7E, ack);
    chk(ack == 0, "R9 data ACK after repeated START", ack, 0);
    readActive = 1;
    txDelay = 3;
    txQ.push_back(8'hC3);
    startCond();
    writeByte({OWN, 1'b1}, ack);
    chk(ack == 0, "R9 read ACK after repeated START", ack, 0);
    readByte(1'b1, v);
    chk(v == 8'hC3, "R9 read byte after direction change", v, 8'hC3);
    readActive = 0;
    stopCond();
    waitC(4*Q);
    chk(expRx.size() == 0, "R4 all expected bytes delivered", expRx.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule